// File: doc/BRIEF.md
# Clock Source Switch Controller

This block sits between software and a clock generator. Software writes two words: a control word and a divider word. The control word enables the output, selects the next clock source and the backup source, sets the primary oscillator mode and the fail-safe settings, and carries three request bits. The divider word stages the prescaler, feedback and two post-divider values. The hardware clears the request bits itself. One request copies the staged prescaler and feedback values into the active set. Another copies the two post-dividers. The third switches the output clock to the source named in the next-source field.

Five clock sources come in as free-running clock inputs, each with a valid flag. Each source has a gate flop clocked on that source's falling edge. A switch closes the old gate first. It opens the new gate only after a two-flop synchronizer in the control clock domain confirms that the old gate is shut. A second synchronizer confirms that the new gate is open, and the ready bit rises after that. A watchdog counter runs on the control clock and watches the active source. If it sees no edge within a programmable number of cycles and fail-safe is on, the block moves to the backup source without software help.

Top module: `clksw_ctrl`

## Requirements
- R1: After reset, the active prescaler, feedback and both post-dividers read 1. The current-source field reads code 1, all request bits read 0, and ready reads 0 until the enable bit (control bit 0) is set. Ready then rises without any switch request.
- R2: Writing the control word with bit 3 set copies the staged prescaler (divider bits 5:0) and feedback (divider bits 15:8) into the active set on the next clock. Bit 3 reads 0 from that cycle on. A staged value of 0 becomes 1.
- R3: Writing the control word with bit 4 set copies the staged first and second post-dividers (divider bits 18:16 and 22:20) into the active set on the next clock. Bit 4 reads 0 from that cycle on. A staged value of 0 becomes 1.
- R4: Writing the divider word changes no active divider until the matching request bit is written. Control fields en, oe, fail-safe (bit 2), mode (7:6), next source (11:8), backup (15:12) and window (23:16) read back as written.
- R5: Setting control bit 5 with a valid, legal next-source code switches the output to that source. Bit 5 then clears, the current-source field (27:24) shows the code, and ready (bit 28) is 1. Source codes are 1, 2, 3, 9 and 10. At most one source gate is open at any time.
- R6: A single control write that carries bits 3, 4 and 5 and a new source code performs both divider copies and the switch.
- R7: A switch request to a source whose valid flag is low leaves the current source active and bit 5 set. The switch completes once the flag rises. Writing bit 5 as 0 cancels the request.
- R8: While the primary mode field reads 11 (disabled), a request to switch to code 3 does not complete.
- R9: Ready reads 0 from the cycle after a switch starts until the new gate is confirmed open.
- R10: With fail-safe on and a nonzero window, if the active source shows no edge for the window length in control-clock cycles, the block switches to the backup source.
- R11: With fail-safe off, a stopped active source does not trigger a switch.
- R12: A switch request with a code outside {1, 2, 3, 9, 10} clears bit 5 and leaves the source unchanged.
- R13: The output clock is held low when the enable bit or the output-enable bit (control bit 1) is 0. Clearing the output enable alone leaves ready unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control word, 1 the divider word |
| wr_data | input | 32 | Write data |
| src_clk | input | 5 | Source clocks, index 0..4 for codes 1, 2, 3, 9, 10 |
| src_valid | input | 5 | Valid flags of the source clocks |
| ctl_rd | output | 32 | Control word readback with current source and ready |
| div_act | output | 32 | Active divider values in divider-word layout |
| clk_out | output | 1 | Gated output clock |

## Verification
Both divider copies and the switch request can land in the same cycle when one control write carries all three bits. The bench issues that write after staging new divider values. Its per-cycle reference model checks that both active divider groups change exactly one clock after the write, while the switch is still under way. Separate checks follow: ready drops one cycle later, the request bit clears only after the handover, and the period of the output clock matches the new source.

// File: rtl/clksw_ctrl.sv
`timescale 1ns/1ps
module clksw_ctrl #(
  parameter int PREW  = 6,
  parameter int FBW   = 8,
  parameter int POSTW = 3,
  parameter int WINW  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  input  logic [4:0]  src_clk,
  input  logic [4:0]  src_valid,
  output logic [31:0] ctl_rd,
  output logic [31:0] div_act,
  output logic        clk_out
);
  localparam int NS = 5;
  localparam logic [2:0] NOIDX = 3'd7;

  typedef enum logic [1:0] {S_IDLE, S_OFF, S_ON} st_t;

  function automatic logic [2:0] c2i(input logic [3:0] c);
    case (c)
      4'd1:    return 3'd0;
      4'd2:    return 3'd1;
      4'd3:    return 3'd2;
      4'd9:    return 3'd3;
      4'd10:   return 3'd4;
      default: return NOIDX;
    endcase
  endfunction

  function automatic logic [3:0] i2c(input logic [2:0] i);
    case (i)
      3'd0:    return 4'd1;
      3'd1:    return 4'd2;
      3'd2:    return 4'd3;
      3'd3:    return 4'd9;
      default: return 4'd10;
    endcase
  endfunction

  logic en_q, oe_q, fs_q, iu_q, ou_q, sw_q;
  logic [1:0] pm_q;
  logic [3:0] nsel_q, bsel_q;
  logic [WINW-1:0] win_q, cnt;
  logic [PREW-1:0] pre_s, pre_a;
  logic [FBW-1:0] fb_s, fb_a;
  logic [POSTW-1:0] p1_s, p2_s, p1_a, p2_a;

  st_t st;
  logic [2:0] cur_q, tgt_q;
  logic rdy_q, fp_q;
  logic [NS-1:0] gate_req, kill, gate_q, vs1, vs2, as1, as2;
  logic ms1, ms2, ms3;
  logic [7:0] vok, ack8, clk8;
  logic [2:0] nidx, bidx;
  logic fail_hit, wr_ctl, wr_div;
  logic unused_bits;

  assign wr_ctl = wr_en & ~wr_sel;
  assign wr_div = wr_en & wr_sel;
  assign unused_bits = ^wr_data;
  assign nidx = c2i(nsel_q);
  assign bidx = c2i(bsel_q);
  assign vok  = {3'b000, vs2 & ~((pm_q == 2'b11) ? 5'b00100 : 5'b00000)};
  assign ack8 = {3'b000, as2};
  assign clk8 = {3'b000, src_clk};
  assign fail_hit = fs_q && (win_q != '0) && (cnt >= win_q) && rdy_q &&
                    (bidx != NOIDX) && (bidx != cur_q) && vok[bidx];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q <= 1'b0; oe_q <= 1'b0; fs_q <= 1'b0; iu_q <= 1'b0; ou_q <= 1'b0;
      pm_q <= 2'b00; nsel_q <= 4'd1; bsel_q <= 4'd2; win_q <= '0;
      pre_s <= '0; fb_s <= '0; p1_s <= '0; p2_s <= '0;
      pre_a <= PREW'(1); fb_a <= FBW'(1); p1_a <= POSTW'(1); p2_a <= POSTW'(1);
    end else begin
      if (iu_q) begin
        pre_a <= (pre_s == '0) ? PREW'(1) : pre_s;
        fb_a  <= (fb_s == '0) ? FBW'(1) : fb_s;
      end
      if (ou_q) begin
        p1_a <= (p1_s == '0) ? POSTW'(1) : p1_s;
        p2_a <= (p2_s == '0) ? POSTW'(1) : p2_s;
      end
      iu_q <= wr_ctl & wr_data[3];
      ou_q <= wr_ctl & wr_data[4];
      if (wr_ctl) begin
        en_q <= wr_data[0]; oe_q <= wr_data[1]; fs_q <= wr_data[2];
        pm_q <= wr_data[7:6]; nsel_q <= wr_data[11:8]; bsel_q <= wr_data[15:12];
        win_q <= wr_data[16 +: WINW];
      end
      if (wr_div) begin
        pre_s <= wr_data[0 +: PREW];
        fb_s  <= wr_data[8 +: FBW];
        p1_s  <= wr_data[16 +: POSTW];
        p2_s  <= wr_data[20 +: POSTW];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vs1 <= '0; vs2 <= '0; as1 <= '0; as2 <= '0;
      ms1 <= 1'b0; ms2 <= 1'b0; ms3 <= 1'b0; cnt <= '0;
    end else begin
      vs1 <= src_valid; vs2 <= vs1;
      as1 <= gate_q;    as2 <= as1;
      ms1 <= clk8[cur_q]; ms2 <= ms1; ms3 <= ms2;
      if (st != S_IDLE || ms2 != ms3) cnt <= '0;
      else if (cnt != '1) cnt <= cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_ON; cur_q <= 3'd0; tgt_q <= 3'd0; gate_req <= NS'(1);
      kill <= '0; rdy_q <= 1'b0; fp_q <= 1'b0; sw_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (fail_hit) begin
            tgt_q <= bidx; gate_req <= '0; kill <= NS'(1) << cur_q;
            rdy_q <= 1'b0; fp_q <= 1'b1; st <= S_OFF;
          end else if (sw_q) begin
            if (nidx == NOIDX || nidx == cur_q) sw_q <= 1'b0;
            else if (vok[nidx]) begin
              tgt_q <= nidx; gate_req <= '0; rdy_q <= 1'b0; fp_q <= 1'b0; st <= S_OFF;
            end
          end
        S_OFF:
          if (!ack8[cur_q]) begin
            gate_req <= NS'(1) << tgt_q; kill <= '0; st <= S_ON;
          end
        S_ON:
          if (ack8[tgt_q]) begin
            cur_q <= tgt_q; rdy_q <= 1'b1; st <= S_IDLE;
            if (!fp_q) sw_q <= 1'b0;
          end
        default: st <= S_IDLE;
      endcase
      if (wr_ctl) sw_q <= wr_data[5];
    end

  for (genvar i = 0; i < NS; i++) begin : g_gate
    logic g, clr_n;
    assign clr_n = rst_n & ~kill[i];
    always_ff @(negedge src_clk[i] or negedge clr_n)
      if (!clr_n) g <= 1'b0;
      else        g <= gate_req[i];
    assign gate_q[i] = g;
  end

  assign clk_out = en_q & oe_q & (|(src_clk & gate_q));

  always_comb begin
    ctl_rd = '0;
    ctl_rd[0] = en_q; ctl_rd[1] = oe_q; ctl_rd[2] = fs_q;
    ctl_rd[3] = iu_q; ctl_rd[4] = ou_q; ctl_rd[5] = sw_q;
    ctl_rd[7:6] = pm_q; ctl_rd[11:8] = nsel_q; ctl_rd[15:12] = bsel_q;
    ctl_rd[16 +: WINW] = win_q;
    ctl_rd[27:24] = i2c(cur_q);
    ctl_rd[28] = rdy_q & en_q;
    div_act = '0;
    div_act[0 +: PREW] = pre_a;
    div_act[8 +: FBW] = fb_a;
    div_act[16 +: POSTW] = p1_a;
    div_act[20 +: POSTW] = p2_a;
  end

  a_r2_in_req_clears: assert property (@(posedge clk) disable iff (!rst_n)
    iu_q && !(wr_ctl && wr_data[3]) |=> !iu_q);
  a_r3_out_req_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ou_q && !(wr_ctl && wr_data[4]) |=> !ou_q);
  a_r2_in_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_a != '0) && (fb_a != '0));
  a_r3_post_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_a != '0) && (p2_a != '0));
  a_r5_one_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gate_q));
  a_r5_cur_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q < 3'd5);
  a_r9_rdy_low_in_switch: assert property (@(posedge clk) disable iff (!rst_n)
    st != S_IDLE |-> !rdy_q);
  a_r7_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE && sw_q && nidx != NOIDX && nidx != cur_q && !vok[nidx] &&
    !fail_hit && !wr_ctl |=> sw_q && $stable(cur_q));
  a_r12_bad_code_drops: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE && sw_q && nidx == NOIDX && !fail_hit && !wr_ctl
    |=> !sw_q && $stable(cur_q));
endmodule

// File: tb/tb_clksw_ctrl.sv
`timescale 1ns/1ps
module tb_clksw_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic s0 = 0, s1 = 0, s2 = 0, s3 = 0, s4 = 0, posc_run = 1'b1;
  logic [4:0] src_clk, src_valid = 5'b00111;
  logic [31:0] ctl_rd, div_act;
  logic clk_out;
  int total = 0, bad = 0, edges = 0;
  bit cmp_on = 0, done = 0;

  logic c_en = 0, c_oe = 0, c_fs = 0;
  logic [1:0] c_pm = 2'b00;
  logic [3:0] c_nsel = 4'd1, c_bsel = 4'd2;
  logic [7:0] c_win = 8'd0;

  int m_pre, m_fb, m_p1, m_p2, s_pre, s_fb, s_p1, s_p2;
  bit m_iu, m_ou;
  logic [23:0] m_st;

  assign src_clk = {s4, s3, s2, s1, s0};

  clksw_ctrl dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .src_clk(src_clk), .src_valid(src_valid),
    .ctl_rd(ctl_rd), .div_act(div_act), .clk_out(clk_out));

  always #2 clk = ~clk;
  always #5 s0 = ~s0;
  always #7 s1 = ~s1;
  always #3 if (posc_run) s2 = ~s2;
  always #9 s3 = ~s3;
  always #11 s4 = ~s4;
  always @(posedge clk_out) edges++;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cword(input bit iu, input bit ou, input bit sw);
    return {8'h00, c_win, c_bsel, c_nsel, c_pm, sw, ou, iu, c_fs, c_oe, c_en};
  endfunction

  task automatic wr(input bit sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_done(input int lim);
    for (int k = 0; k < lim; k++) begin
      if (!ctl_rd[5] && ctl_rd[28]) break;
      @(negedge clk);
    end
  endtask

  task automatic period(output int p);
    realtime t0;
    @(posedge clk_out); t0 = $realtime;
    @(posedge clk_out); p = $rtoi($realtime - t0 + 0.5);
  endtask

  // behavioural model of the register side, advanced at every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 1; m_fb = 1; m_p1 = 1; m_p2 = 1;
      s_pre = 0; s_fb = 0; s_p1 = 0; s_p2 = 0;
      m_iu = 0; m_ou = 0; m_st = 24'h002100;
    end else begin
      if (m_iu) begin m_pre = (s_pre == 0) ? 1 : s_pre; m_fb = (s_fb == 0) ? 1 : s_fb; end
      if (m_ou) begin m_p1 = (s_p1 == 0) ? 1 : s_p1; m_p2 = (s_p2 == 0) ? 1 : s_p2; end
      m_iu = wr_en && !wr_sel && wr_data[3];
      m_ou = wr_en && !wr_sel && wr_data[4];
      if (wr_en && !wr_sel) m_st = wr_data[23:0] & 24'hFFFFC7;
      if (wr_en && wr_sel) begin
        s_pre = int'(wr_data[5:0]); s_fb = int'(wr_data[15:8]);
        s_p1 = int'(wr_data[18:16]); s_p2 = int'(wr_data[22:20]);
      end
    end
  end

  always @(negedge clk) if (cmp_on) begin
    chk("R2/R3 active dividers", int'(div_act),
        m_pre | (m_fb << 8) | (m_p1 << 16) | (m_p2 << 20));
    chk("R2/R3 request bits", int'(ctl_rd[4:3]), int'({m_ou, m_iu}));
    chk("R4 control readback", int'(ctl_rd[23:0] & 24'hFFFFC7), int'(m_st));
  end

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int p, e0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; cmp_on = 1;
    @(negedge clk);
    chk("R1 reset dividers", int'(div_act), 32'h00110101);
    chk("R1 reset source", int'(ctl_rd[27:24]), 1);
    chk("R1 reset requests", int'(ctl_rd[5:3]), 0);
    repeat (20) @(negedge clk);
    chk("R1 ready off while disabled", int'(ctl_rd[28]), 0);
    c_en = 1; c_oe = 1; wr(0, cword(0, 0, 0));
    wait_done(50);
    chk("R1 ready after enable", int'(ctl_rd[28]), 1);
    period(p); chk("R1 output runs on code 1", p, 10);

    wr(1, 32'h0); wr(0, cword(1, 1, 0)); @(negedge clk);
    chk("R2 R3 zero treated as one", int'(div_act), 32'h00110101);
    wr(1, (1 << 20) | (5 << 16) | (100 << 8) | 2);
    repeat (3) @(negedge clk);
    chk("R4 staging alone", int'(div_act), 32'h00110101);
    wr(0, cword(1, 0, 0)); @(negedge clk);
    chk("R2 input commit", int'(div_act), 32'h00116402);
    wr(0, cword(0, 1, 0)); @(negedge clk);
    chk("R3 output commit", int'(div_act), 32'h00156402);

    wr(1, (2 << 20) | (3 << 16) | (50 << 8) | 1);
    c_pm = 2'b10; c_nsel = 4'd3; wr(0, cword(1, 1, 1));
    @(negedge clk);
    chk("R6 both copies in one write", int'(div_act), 32'h00233201);
    chk("R9 ready low in switch", int'(ctl_rd[28]), 0);
    chk("R9 request still set", int'(ctl_rd[5]), 1);
    wait_done(80);
    chk("R6 switch done", int'(ctl_rd[27:24]), 3);
    chk("R5 request cleared", int'(ctl_rd[5]), 0);
    period(p); chk("R5 output follows code 3", p, 6);

    c_nsel = 4'd9; wr(0, cword(0, 0, 1));
    repeat (100) @(negedge clk);
    chk("R7 invalid target waits", int'(ctl_rd[5]), 1);
    chk("R7 source kept", int'(ctl_rd[27:24]), 3);
    chk("R7 ready kept", int'(ctl_rd[28]), 1);
    src_valid[3] = 1'b1;
    wait_done(80);
    chk("R7 completes once valid", int'(ctl_rd[27:24]), 9);
    period(p); chk("R5 output follows code 9", p, 18);

    c_nsel = 4'd10; wr(0, cword(0, 0, 1));
    repeat (20) @(negedge clk);
    chk("R7 pending", int'(ctl_rd[5]), 1);
    wr(0, cword(0, 0, 0));
    chk("R7 cancel", int'(ctl_rd[5]), 0);
    repeat (20) @(negedge clk);
    chk("R7 cancel keeps source", int'(ctl_rd[27:24]), 9);

    c_pm = 2'b11; c_nsel = 4'd3; wr(0, cword(0, 0, 1));
    repeat (100) @(negedge clk);
    chk("R8 disabled primary blocks", int'(ctl_rd[27:24]), 9);
    chk("R8 request stays", int'(ctl_rd[5]), 1);
    wr(0, cword(0, 0, 0)); c_pm = 2'b10;

    c_nsel = 4'd5; wr(0, cword(0, 0, 1));
    repeat (5) @(negedge clk);
    chk("R12 bad code dropped", int'(ctl_rd[5]), 0);
    chk("R12 source unchanged", int'(ctl_rd[27:24]), 9);

    c_nsel = 4'd3; wr(0, cword(0, 0, 1));
    wait_done(80);
    chk("R5 back to code 3", int'(ctl_rd[27:24]), 3);
    c_win = 8'd16; c_fs = 0; c_bsel = 4'd2; wr(0, cword(0, 0, 0));
    posc_run = 1'b0;
    repeat (100) @(negedge clk);
    chk("R11 no fallback when off", int'(ctl_rd[27:24]), 3);
    c_fs = 1; wr(0, cword(0, 0, 0));
    for (int k = 0; k < 100; k++) begin
      if (ctl_rd[27:24] == 4'd2 && ctl_rd[28]) break;
      @(negedge clk);
    end
    chk("R10 fallback to backup", int'(ctl_rd[27:24]), 2);
    chk("R10 ready after fallback", int'(ctl_rd[28]), 1);
    period(p); chk("R10 output follows backup", p, 14);

    c_oe = 0; wr(0, cword(0, 0, 0));
    @(negedge clk); e0 = edges;
    repeat (50) @(negedge clk);
    chk("R13 output enable off", edges - e0, 0);
    chk("R13 ready kept", int'(ctl_rd[28]), 1);
    c_oe = 1; c_en = 0; wr(0, cword(0, 0, 0));
    @(negedge clk); e0 = edges;
    repeat (50) @(negedge clk);
    chk("R13 disabled output", edges - e0, 0);
    chk("R13 ready off when disabled", int'(ctl_rd[28]), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule